// File: doc/BRIEF.md
# Decoder Self-Test Engine with Parity Response Check

This block wraps a one-hot line decoder with its own test logic so that the decoder can be checked in place without an external tester. When a run is requested, an internal binary counter applies every select code to the decoder once. Each resulting output word is compressed into a single parity bit. A healthy decoder raises exactly one line per code, so every word must have odd parity. An even result on any code marks the decoder as faulty.

The block needs no table of expected responses. The one-hot property of a correct decoder is the only reference, and one XOR reduction checks it. For exercising the checker itself, a fault-forcing input can hold any single decoder output line at a fixed level for a whole run. This mimics a stuck-at-0 or stuck-at-1 defect on that line.

A run is started with a one-cycle request while the engine is idle or finished. The result stays on the outputs until the next request.

Top module: `dec_selftest`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pass_o` and `fail_o` are all low.
- R2: A high `start_i` while idle or finished makes `busy_o` high from the next cycle on. The run then lasts exactly 2^SEL_W cycles (8 by default). After that, `busy_o` drops and `done_o` rises in the same cycle.
- R3: During a run the counter applies each select code from 0 up to 2^SEL_W-1 exactly once. Code k drives decoder line k, and only line k, high.
- R4: If any applied code yields an output word with an even number of high lines, a sticky fault flag is set for the rest of the run. If every word has odd parity, the run passes.
- R5: While `inject_en_i` is high, decoder line `inject_line_i` is held at `inject_level_i` (1 = stuck high, 0 = stuck low) before the parity check. No other line is affected.
- R6: A stuck-high fault on any single line is reported as a failure at the end of the run.
- R7: A stuck-low fault on any single line is reported as a failure at the end of the run.
- R8: `start_i` has no effect while `busy_o` is high. The run neither restarts nor lengthens.
- R9: `pass_o` and `fail_o` are low unless `done_o` is high. While `done_o` is high, exactly one of them is high.
- R10: `done_o` and the result hold until the next start, whatever the fault-forcing inputs do. A new start clears the previous fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a self-test run |
| inject_en_i | input | 1 | Enable forcing of one decoder output line |
| inject_line_i | input | SEL_W | Index of the line to force |
| inject_level_i | input | 1 | Level the forced line is held at |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid |
| pass_o | output | 1 | All patterns had odd parity (valid with done) |
| fail_o | output | 1 | At least one pattern had even parity (valid with done) |

## Verification
The bench forces every line stuck high and stuck low, including the first and last code, where an off-by-one counter would skip the faulty pattern and report a pass. It issues start requests in the middle of a run and on its final cycle; a design that honoured them would finish late or restart. A passing run directly after a failing one catches a fault flag that is never cleared. Fault-forcing inputs are toggled while the result is held, to catch a result that is still computed live after the run.

// File: rtl/dec_selftest_pkg.sv
package dec_selftest_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dst_state_e;

endpackage

// File: rtl/dst_onehot_dec.sv
module dst_onehot_dec #(
    parameter int SEL_W = 3,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] code_i,
    output logic [LINES-1:0] line_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_o[i] = (code_i == SEL_W'(i));
    end

endmodule

// File: rtl/dst_line_force.sv
module dst_line_force #(
    parameter int SEL_W = 3,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [LINES-1:0] line_i,
    input  logic             force_en_i,
    input  logic [SEL_W-1:0] force_idx_i,
    input  logic             force_val_i,
    output logic [LINES-1:0] line_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_force
        logic hit;
        assign hit       = force_en_i && (force_idx_i == SEL_W'(i));
        assign line_o[i] = hit ? force_val_i : line_i[i];
    end

endmodule

// File: rtl/dst_parity_chk.sv
module dst_parity_chk #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             odd_o
);

    // Fold the word one bit at a time; a correct one-hot word folds to 1.
    logic [WIDTH:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < WIDTH; i++) begin : g_fold
        assign chain[i+1] = chain[i] ^ word_i[i];
    end
    assign odd_o = chain[WIDTH];

endmodule

// File: rtl/dec_selftest.sv
module dec_selftest
    import dec_selftest_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             inject_en_i,
    input  logic [SEL_W-1:0] inject_line_i,
    input  logic             inject_level_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o
);

    localparam int LINES = 1 << SEL_W;
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(LINES - 1);

    typedef struct packed {
        dst_state_e       state;
        logic [SEL_W-1:0] code;
        logic             fault;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [LINES-1:0] dec_lines;
    logic [LINES-1:0] chk_lines;
    logic             par_ok;
    logic             fault_flag;

    dst_onehot_dec #(.SEL_W(SEL_W)) u_dec (
        .code_i (r_q.code),
        .line_o (dec_lines)
    );

    dst_line_force #(.SEL_W(SEL_W)) u_force (
        .line_i      (dec_lines),
        .force_en_i  (inject_en_i),
        .force_idx_i (inject_line_i),
        .force_val_i (inject_level_i),
        .line_o      (chk_lines)
    );

    dst_parity_chk #(.WIDTH(LINES)) u_par (
        .word_i (chk_lines),
        .odd_o  (par_ok)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state = ST_RUN;
                    r_d.code  = '0;
                    r_d.fault = 1'b0;
                end
            end
            ST_RUN: begin
                if (!par_ok) begin
                    r_d.fault = 1'b1;
                end
                r_d.code = r_q.code + 1'b1;
                if (r_q.code == LAST_CODE) begin
                    r_d.state = ST_DONE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, code: '0, fault: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fault_flag = r_q.fault;
    assign busy_o     = (r_q.state == ST_RUN);
    assign done_o     = (r_q.state == ST_DONE);
    assign pass_o     = done_o && !fault_flag;
    assign fail_o     = done_o && fault_flag;

endmodule

// File: rtl/dec_selftest_checks.sv
module dec_selftest_checks #(
    parameter int SEL_W = 3
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic pass_o,
    input logic fail_o,
    input logic par_ok,
    input logic fault_flag
);

    localparam int LINES = 1 << SEL_W;
    localparam int CW = SEL_W + 2;

    logic [CW-1:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (busy_o) begin
            run_len_q <= run_len_q + 1'b1;
        end else begin
            run_len_q <= '0;
        end
    end

    p_run_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len_q == CW'(LINES)) && done_o);

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_even_sets_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !par_ok) |=> fault_flag);

    p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && fault_flag) |=> fault_flag);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && run_len_q < CW'(LINES - 1)) |=> busy_o);

    p_pass_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fail_o) |-> done_o);

    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones({pass_o, fail_o}) == 1);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(pass_o));

endmodule

bind dec_selftest dec_selftest_checks #(.SEL_W(SEL_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .par_ok     (par_ok),
    .fault_flag (fault_flag)
);

// File: tb/dec_selftest_test.sv
module dec_selftest_test;

    localparam int CLK_PERIOD = 10;
    localparam int SEL_W = 3;
    localparam int LINES = 1 << SEL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             inject_en_i = 1'b0;
    logic [SEL_W-1:0] inject_line_i = '0;
    logic             inject_level_i = 1'b0;
    logic             busy_o, done_o, pass_o, fail_o;

    int n_checks = 0;
    int n_fails = 0;

    dec_selftest #(.SEL_W(SEL_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .inject_en_i    (inject_en_i),
        .inject_line_i  (inject_line_i),
        .inject_level_i (inject_level_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .pass_o         (pass_o),
        .fail_o         (fail_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected verdict from the requirements: code k lights line k only,
    // the forced line takes the forced level, even parity on any code fails.
    function automatic bit exp_fail(input bit en, input int idx, input bit lvl);
        for (int k = 0; k < LINES; k++) begin
            logic [LINES-1:0] w;
            w = '0;
            w[k] = 1'b1;
            if (en) w[idx] = lvl;
            if (($countones(w) % 2) == 0) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Run one test; restart_at in 1..LINES-1 pulses start mid-run (R8).
    task automatic do_run(input bit en, input int idx, input bit lvl,
                          input int restart_at, input string req);
        bit ef;
        ef = exp_fail(en, idx, lvl);
        @(negedge clk);
        inject_en_i    = en;
        inject_line_i  = SEL_W'(idx);
        inject_level_i = lvl;
        start_i        = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1 && done_o === 1'b0, "R2 busy after start", busy_o, 1);
        for (int i = 1; i < LINES; i++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = (i == restart_at);
        end
        check(busy_o === 1'b1 && done_o === 1'b0, "R2 still running before last code", done_o, 0);
        check(pass_o === 1'b0 && fail_o === 1'b0, "R9 no verdict while busy", pass_o + fail_o, 0);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b1 && busy_o === 1'b0, "R2 R8 done after exact run length", done_o, 1);
        check(fail_o === ef, {req, " fail verdict"}, fail_o, ef);
        check(pass_o === !ef, {req, " pass verdict"}, pass_o, !ef);
        // R10: result holds while fault-forcing inputs wander
        inject_en_i    = ~en;
        inject_level_i = ~lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done_o === 1'b1 && fail_o === ef && pass_o === !ef,
              "R10 result held", fail_o, ef);
        inject_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0d17;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(busy_o === 1'b0 && done_o === 1'b0 && pass_o === 1'b0 && fail_o === 1'b0,
              "R1 outputs low in reset", busy_o + done_o + pass_o + fail_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && pass_o === 1'b0 && fail_o === 1'b0,
              "R1 idle after reset", busy_o + done_o + pass_o + fail_o, 0);

        // R3 R4 healthy run passes
        do_run(1'b0, 0, 1'b0, 0, "R3 R4 healthy");
        // R6 stuck-high on every line, R7 stuck-low on every line
        for (int l = 0; l < LINES; l++) begin
            do_run(1'b1, l, 1'b1, 0, "R5 R6 stuck-high");
            do_run(1'b1, l, 1'b0, 0, "R5 R7 stuck-low");
        end
        // R10 pass right after a fail: flag cleared by new start
        do_run(1'b1, LINES - 1, 1'b0, 0, "R7 last line low");
        do_run(1'b0, 0, 1'b0, 0, "R10 cleared after restart");
        // R8 start mid-run and on the last run cycle
        do_run(1'b0, 0, 1'b0, 3, "R8 start mid-run");
        do_run(1'b1, 2, 1'b1, LINES - 1, "R8 start on final cycle");
        // constrained random runs
        for (int n = 0; n < 40; n++) begin
            bit en, lvl;
            int idx, rs;
            en  = ($urandom % 3) != 0;
            lvl = $urandom % 2;
            idx = $urandom % LINES;
            rs  = (($urandom % 4) == 0) ? 1 + ($urandom % (LINES - 1)) : 0;
            do_run(en, idx, lvl, rs, "R4 R5 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule